// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block sits beside a descriptor ring and decides when the host is told that work has finished. Each finished descriptor produces a one-cycle completion pulse, and the ring tracker supplies the number of completions still waiting for software. Instead of interrupting on every pulse, the coalescer waits until enough completions have piled up, or until a programmable idle time has passed with work still waiting. It then raises a message-signalled interrupt: a single memory write request that carries a programmed data word to a programmed 48-bit address.

Software programs two configuration words and three message words. The first configuration word holds the count threshold in bits [14:0] and the timer enable in bit 18; its other bits are ignored. The second holds the timeout threshold in bits [12:0]. The message words are a 32-bit low address, a 16-bit high address and a 32-bit data word. Thresholds such as 0x14 completions and 0xB0 timer ticks are normal settings.

The request leaves on a valid/ready output. Back-pressure rules: once `msg_valid` is high it stays high, with address and data unchanged, until a clock edge at which `msg_ready` is also high. Address and data are captured when the request is launched, so later changes to the message words do not alter a request that is already waiting. Only one request exists at a time, and no new one is started while one is waiting.

Top module: `cpl_irq_coalescer`

## Requirements
- R1: After reset `msg_valid` is low and stays low while no completion pulse arrives.
- R2: The block is armed by a completion pulse on `cpl_evt`. While armed and idle, a request is launched in any cycle where `pend_count` is non-zero and at least the count threshold `cfg_thr_reg[14:0]`. `msg_valid` goes high on the next clock edge. A threshold of 0x14 fires at 20 pending and not at 19.
- R3: With `cfg_thr_reg[18]` set, a tick counter starts at zero and counts one per clock while the block is armed, idle and `pend_count` is non-zero. When it equals `cfg_tmo_reg[12:0]` (T), a request is launched. If counting starts right after edge E0, `msg_valid` is low after edge E0+T and high after edge E0+T+1. The counter returns to zero on launch or when counting stops.
- R4: With `cfg_thr_reg[18]` clear, no request is issued by the timer however long completions stay pending below the count threshold; bits 15 to 17 of `cfg_thr_reg` have no effect.
- R5: No request is launched while `pend_count` is zero, even when armed with a count threshold of zero.
- R6: `msg_addr` is `{cfg_addr_hi, cfg_addr_lo}` and `msg_data` is `cfg_data`, both as sampled in the launch cycle.
- R7: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold. `msg_valid` falls on the edge where `msg_ready` is high, unless a new request follows.
- R8: A launch disarms the block; with no new pulse and no drop in `pend_count`, no further request follows, even though `pend_count` stays at or above the threshold.
- R9: A drop in `pend_count` below its previous cycle's value re-arms the block. It fires again if the count is still at or above the threshold, and does not fire if the count is now below it.
- R10: A completion pulse in the same cycle as a launch leaves the block armed, so a second request follows the cycle after the first is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_evt | input | 1 | One-cycle pulse per finished descriptor |
| pend_count | input | 15 | Completions awaiting software, from the ring tracker |
| cfg_thr_reg | input | 32 | Count threshold [14:0], timer enable [18] |
| cfg_tmo_reg | input | 32 | Timeout threshold [12:0] |
| cfg_addr_lo | input | 32 | Message address bits [31:0] |
| cfg_addr_hi | input | 16 | Message address bits [47:32] |
| cfg_data | input | 32 | Message data word |
| msg_valid | output | 1 | Write request is waiting |
| msg_ready | input | 1 | Fabric accepts the request at this edge |
| msg_addr | output | 48 | Write address of the request |
| msg_data | output | 32 | Write data of the request |

## Verification
The arming flag can be both set and cleared in one cycle. This happens when a completion pulse lands in the cycle where a request is launched, and R10 requires the set to win. The bench provokes this by raising the count to the threshold together with a pulse. It then checks that a second request appears exactly one cycle after the first is accepted. A matching scenario without the coincident pulse must produce no second request, and the two results are compared.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int CNT_W      = 15;  // count threshold field and pending count
  localparam int TMR_W      = 13;  // timeout threshold field
  localparam int TMR_EN_BIT = 18;  // timer enable position in the threshold word
  localparam int REG_W      = 32;  // configuration word width
  localparam int ADDR_HI_W  = 16;  // used part of the high address word
  localparam int DATA_W     = 32;  // message data width
endpackage

// File: rtl/coal_arm.sv
module coal_arm #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpl_evt,
  input  logic [CNT_W-1:0] pend,
  input  logic [CNT_W-1:0] cnt_thr,
  input  logic             busy,
  input  logic             tmr_hit,
  output logic             armed,
  output logic             pend_nz,
  output logic             launch
);
  logic [CNT_W-1:0] pend_q;
  logic             released;
  logic             cnt_hit;

  assign pend_nz  = |pend;
  assign released = pend < pend_q;
  assign cnt_hit  = pend >= cnt_thr;
  assign launch   = armed & ~busy & pend_nz & (cnt_hit | tmr_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      pend_q <= '0;
    end else begin
      pend_q <= pend;
      if (cpl_evt || released) armed <= 1'b1;
      else if (launch)         armed <= 1'b0;
    end
  end

  AST_COINCIDE_KEEPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && cpl_evt) |=> armed); // R10
endmodule

// File: rtl/coal_timer.sv
module coal_timer #(
  parameter int TMR_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [TMR_W-1:0] thr,
  input  logic             armed,
  input  logic             pend_nz,
  input  logic             busy,
  input  logic             launch,
  output logic             hit
);
  localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};

  logic [TMR_W-1:0] tick_q;
  logic             counting;

  assign counting = en & armed & pend_nz & ~busy;
  assign hit      = counting & (tick_q >= thr);

  always_ff @(posedge clk) begin
    if (!rst_n)                    tick_q <= '0;
    else if (!counting || launch)  tick_q <= '0;
    else if (tick_q != TMR_MAX)    tick_q <= tick_q + 1'b1;
  end

  AST_TMR_HIT_LAUNCHES: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> launch); // R3
endmodule

// File: rtl/coal_msg.sv
module coal_msg #(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else if (launch) begin
      valid <= 1'b1;
      addr  <= addr_in;
      data  <= data_in;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(addr) && $stable(data))); // R7
endmodule

// File: rtl/cpl_irq_coalescer.sv
module cpl_irq_coalescer #(
  parameter int CNT_W      = coal_pkg::CNT_W,
  parameter int TMR_W      = coal_pkg::TMR_W,
  parameter int TMR_EN_BIT = coal_pkg::TMR_EN_BIT,
  parameter int REG_W      = coal_pkg::REG_W,
  parameter int ADDR_HI_W  = coal_pkg::ADDR_HI_W,
  parameter int DATA_W     = coal_pkg::DATA_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpl_evt,
  input  logic [CNT_W-1:0]            pend_count,
  input  logic [REG_W-1:0]            cfg_thr_reg,
  input  logic [REG_W-1:0]            cfg_tmo_reg,
  input  logic [REG_W-1:0]            cfg_addr_lo,
  input  logic [ADDR_HI_W-1:0]        cfg_addr_hi,
  input  logic [DATA_W-1:0]           cfg_data,
  output logic                        msg_valid,
  input  logic                        msg_ready,
  output logic [REG_W+ADDR_HI_W-1:0]  msg_addr,
  output logic [DATA_W-1:0]           msg_data
);
  localparam int ADDR_W = REG_W + ADDR_HI_W;

  logic [CNT_W-1:0]  cnt_thr;
  logic [TMR_W-1:0]  tmr_thr;
  logic              tmr_en;
  logic [ADDR_W-1:0] addr_cat;
  logic              armed, pend_nz, launch, tmr_hit;
  logic              cfg_unused;

  assign cnt_thr    = cfg_thr_reg[CNT_W-1:0];
  assign tmr_en     = cfg_thr_reg[TMR_EN_BIT];
  assign tmr_thr    = cfg_tmo_reg[TMR_W-1:0];
  assign addr_cat   = {cfg_addr_hi, cfg_addr_lo};
  assign cfg_unused = ^{cfg_thr_reg, cfg_tmo_reg};

  coal_arm #(.CNT_W(CNT_W)) u_arm (
    .clk(clk), .rst_n(rst_n), .cpl_evt(cpl_evt), .pend(pend_count),
    .cnt_thr(cnt_thr), .busy(msg_valid), .tmr_hit(tmr_hit),
    .armed(armed), .pend_nz(pend_nz), .launch(launch)
  );

  coal_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(tmr_en), .thr(tmr_thr), .armed(armed),
    .pend_nz(pend_nz), .busy(msg_valid), .launch(launch), .hit(tmr_hit)
  );

  coal_msg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_msg (
    .clk(clk), .rst_n(rst_n), .launch(launch), .addr_in(addr_cat),
    .data_in(cfg_data), .ready(msg_ready), .valid(msg_valid),
    .addr(msg_addr), .data(msg_data)
  );

  AST_NO_MSG_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(pend_count != '0)); // R5
  AST_MSG_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(armed)); // R8
endmodule

// File: tb/sim_cpl_irq_coalescer.sv
`timescale 1ns/1ps
module sim_cpl_irq_coalescer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpl_evt;
  logic [14:0] pend;
  logic [31:0] cfg_thr_reg, cfg_tmo_reg, cfg_addr_lo, cfg_data;
  logic [15:0] cfg_addr_hi;
  logic        msg_valid, msg_ready;
  logic [47:0] msg_addr;
  logic [31:0] msg_data;
  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cpl_irq_coalescer u0 (
    .clk(clk), .rst_n(rst_n), .cpl_evt(cpl_evt), .pend_count(pend),
    .cfg_thr_reg(cfg_thr_reg), .cfg_tmo_reg(cfg_tmo_reg),
    .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi), .cfg_data(cfg_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; cpl_evt = 1'b0; pend = '0; msg_ready = 1'b0;
    cfg_thr_reg = 32'h14; cfg_tmo_reg = 32'hB0;
    cfg_addr_lo = 32'h1000_0040; cfg_addr_hi = 16'h00F0; cfg_data = 32'h55;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic pulse(input int p);
    pend = p[14:0]; cpl_evt = 1'b1;
    step(1);
    cpl_evt = 1'b0;
  endtask

  task automatic accept;
    msg_ready = 1'b1;
    step(1);
    msg_ready = 1'b0;
  endtask

  task automatic t_reset;
    do_reset();
    chk("R1", "valid after reset", msg_valid, 0);
    pend = 15'd30;
    step(10);
    chk("R1", "valid without pulse", msg_valid, 0);
  endtask

  task automatic t_count;
    do_reset();
    cfg_addr_lo = 32'h89AB_CDEF; cfg_addr_hi = 16'h5A5A; cfg_data = 32'hC0FF_EE01;
    for (int k = 1; k < 20; k++) begin
      pulse(k);
      step(1);
    end
    chk("R2", "valid at 19 pending", msg_valid, 0);
    pulse(20);
    step(1);
    chk("R2", "valid at 20 pending", msg_valid, 1);
    chk("R6", "address", msg_addr, 48'h5A5A_89AB_CDEF);
    chk("R6", "data", msg_data, 32'hC0FF_EE01);
    cfg_addr_lo = 32'h0; cfg_addr_hi = 16'h0; cfg_data = 32'h0;
    step(4);
    chk("R7", "valid held", msg_valid, 1);
    chk("R7", "address held", msg_addr, 48'h5A5A_89AB_CDEF);
    chk("R7", "data held", msg_data, 32'hC0FF_EE01);
    accept();
    chk("R7", "valid after accept", msg_valid, 0);
  endtask

  task automatic t_norefire;
    do_reset();
    pulse(22);
    step(1);
    chk("R8", "first message", msg_valid, 1);
    accept();
    step(10);
    chk("R8", "no refire", msg_valid, 0);
    pend = 15'd21;
    step(2);
    chk("R9", "release above threshold fires", msg_valid, 1);
    accept();
    pend = 15'd15;
    step(3);
    chk("R9", "release below threshold quiet", msg_valid, 0);
  endtask

  task automatic t_timer;
    do_reset();
    cfg_thr_reg = (32'h1 << 18) | 32'h14;
    cfg_tmo_reg = 32'hB0;
    cfg_addr_hi = 16'hBEEF;
    pulse(1);
    step(176);
    chk("R3", "no timeout before threshold", msg_valid, 0);
    step(1);
    chk("R3", "timeout message", msg_valid, 1);
    chk("R6", "timeout address", msg_addr, 48'hBEEF_1000_0040);
  endtask

  task automatic t_timer_off;
    do_reset();
    cfg_thr_reg = 32'h0003_8014;
    cfg_tmo_reg = 32'h5;
    pulse(1);
    step(60);
    chk("R4", "timer disabled quiet", msg_valid, 0);
    cfg_thr_reg = cfg_thr_reg | (32'h1 << 18);
    step(5);
    chk("R3", "enabled not yet", msg_valid, 0);
    step(1);
    chk("R3", "enabled fires", msg_valid, 1);
  endtask

  task automatic t_zero;
    do_reset();
    cfg_thr_reg = 32'h1 << 18;
    cfg_tmo_reg = 32'h3;
    pulse(0);
    step(20);
    chk("R5", "no message when empty", msg_valid, 0);
    pulse(1);
    step(1);
    chk("R5", "fires once non-empty", msg_valid, 1);
  endtask

  task automatic t_coincide;
    do_reset();
    pulse(19);
    step(1);
    chk("R10", "armed below threshold", msg_valid, 0);
    pend = 15'd20; cpl_evt = 1'b1;
    step(1);
    cpl_evt = 1'b0;
    chk("R10", "first message", msg_valid, 1);
    accept();
    chk("R10", "gap after accept", msg_valid, 0);
    step(1);
    chk("R10", "second message", msg_valid, 1);
    accept();
    step(5);
    chk("R10", "no third message", msg_valid, 0);
  endtask

  initial begin
    t_reset();
    t_count();
    t_norefire();
    t_timer();
    t_timer_off();
    t_zero();
    t_coincide();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule